// File: doc/BRIEF.md
# Coalescing Write Buffer

This block sits between a write-through cache and the next memory level. Processor stores enter through a valid/ready write port and take a slot holding an address, a data word and per-byte enables. Slots drain to memory oldest first over a valid/ready port, and a slot is released only when memory takes it.

A new store to an address that is already pending is folded into that slot instead of taking a new one. Its enabled bytes overwrite the stored bytes and its enables are ORed in. The oldest slot is the one currently offered to memory, so it is never a merge target. A store to its address takes a fresh slot.

A lookup port lets the cache check a read miss against every pending slot in the same cycle. On a miss the read can go to memory ahead of the queued stores. On a hit the buffer supplies the newest buffered bytes for that address, and the read does not need to be issued.

Top module: `cwb_top`

## Requirements
- R1: Reset (rst_n low, sampled on the clock edge) discards all slots: empty is 1, full is 0, mem_valid is 0 and wr_ready is 1.
- R2: mem_valid equals not-empty. The port always offers the oldest pending slot, and slots leave in the order their first store was accepted. While mem_valid is high and mem_ready is low, mem_addr, mem_data and mem_be stay unchanged.
- R3: A slot is released only in a cycle where mem_valid and mem_ready are both high. With all slots full and no such handshake, full stays high.
- R4: An accepted store whose address equals that of a pending slot other than the oldest is merged into that slot and takes no new slot. Each byte i (bits 8i+7..8i) with wr_be[i] set is overwritten, and the slot's enables become the OR of old and new.
- R5: The oldest pending slot is never a merge target. A store to its address is placed in a new slot behind it.
- R6: wr_ready is low exactly when every slot is valid and wr_addr matches no pending slot other than the oldest. full is high when every slot is valid.
- R7: rd_hit is high in the same cycle, combinationally, when rd_req is high and rd_addr equals the address of any pending slot. It is low when rd_req is low or nothing matches.
- R8: On a hit, each byte of rd_data comes from the newest matching slot that enables that byte. rd_be is the OR of the enables of all matching slots. Bytes that no matching slot enables read as zero.
- R9: When a store takes a new slot, bytes whose enable is clear are stored as zero. mem_data shows them as zero when that slot drains.
- R10: Address comparison for merging and lookup uses every address bit. Addresses that differ only in the top bit neither merge nor hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_valid | input | 1 | Store offered |
| wr_ready | output | 1 | Store can be accepted this cycle |
| wr_addr | input | ADDR_W | Store word address |
| wr_data | input | DATA_W | Store data |
| wr_be | input | DATA_W/8 | Store byte enables |
| rd_req | input | 1 | Read-miss lookup request |
| rd_addr | input | ADDR_W | Lookup address |
| rd_hit | output | 1 | Lookup matches a pending slot |
| rd_data | output | DATA_W | Forwarded bytes on a hit |
| rd_be | output | DATA_W/8 | Which forwarded bytes are valid |
| mem_valid | output | 1 | Oldest slot offered to memory |
| mem_ready | input | 1 | Memory accepts the offered slot |
| mem_addr | output | ADDR_W | Address of offered slot |
| mem_data | output | DATA_W | Data of offered slot |
| mem_be | output | DATA_W/8 | Byte enables of offered slot |
| full | output | 1 | All slots valid |
| empty | output | 1 | No slot valid |

## Verification
A wrong head or tail pointer shows up on the memory port at the next drain, as a wrong address or a changed order. A wrong valid bit shows up in the same cycle on full, empty or wr_ready. A merge sent to the wrong slot, or allowed into the oldest slot, appears as wrong mem_data or mem_be when that slot drains. A lookup made right after the merge shows the same fault as wrong rd_data in the same cycle, so forwarding faults are caught before any drain happens.

// File: rtl/cwb_pkg.sv
package cwb_pkg;
    localparam int unsigned CWB_ADDR_W = 32;
    localparam int unsigned CWB_DATA_W = 32;
    localparam int unsigned CWB_DEPTH  = 4;
    localparam int unsigned CWB_BYTE_W = 8;
endpackage

// File: rtl/cwb_match.sv
module cwb_match #(
    parameter int unsigned DEPTH  = 4,
    parameter int unsigned ADDR_W = 32
) (
    input  logic [DEPTH-1:0]             slot_vld,
    input  logic [DEPTH-1:0][ADDR_W-1:0] slot_addr,
    input  logic [ADDR_W-1:0]            key,
    output logic [DEPTH-1:0]             hit
);
    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        assign hit[g] = slot_vld[g] && (slot_addr[g] == key);
    end
endmodule

// File: rtl/cwb_fwd.sv
module cwb_fwd #(
    parameter int unsigned DEPTH  = 4,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned PTR_W  = 2
) (
    input  logic [DEPTH-1:0]                 sel,
    input  logic [PTR_W-1:0]                 oldest,
    input  logic [DEPTH-1:0][DATA_W-1:0]     slot_data,
    input  logic [DEPTH-1:0][DATA_W/8-1:0]   slot_be,
    output logic [DATA_W-1:0]                out_data,
    output logic [DATA_W/8-1:0]              out_be
);
    localparam int unsigned BE_W = DATA_W / 8;

    always_comb begin
        out_data = '0;
        out_be   = '0;
        // walk from oldest to newest so later slots win per byte
        for (int k = 0; k < DEPTH; k++) begin
            int idx;
            idx = int'(oldest) + k;
            if (idx >= DEPTH) idx = idx - DEPTH;
            if (sel[idx]) begin
                for (int b = 0; b < BE_W; b++) begin
                    if (slot_be[idx][b]) begin
                        out_data[b*8 +: 8] = slot_data[idx][b*8 +: 8];
                        out_be[b]          = 1'b1;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/cwb_top.sv
module cwb_top
    import cwb_pkg::*;
#(
    parameter int unsigned ADDR_W = CWB_ADDR_W,
    parameter int unsigned DATA_W = CWB_DATA_W,
    parameter int unsigned DEPTH  = CWB_DEPTH
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_valid,
    output logic                  wr_ready,
    input  logic [ADDR_W-1:0]     wr_addr,
    input  logic [DATA_W-1:0]     wr_data,
    input  logic [DATA_W/8-1:0]   wr_be,
    input  logic                  rd_req,
    input  logic [ADDR_W-1:0]     rd_addr,
    output logic                  rd_hit,
    output logic [DATA_W-1:0]     rd_data,
    output logic [DATA_W/8-1:0]   rd_be,
    output logic                  mem_valid,
    input  logic                  mem_ready,
    output logic [ADDR_W-1:0]     mem_addr,
    output logic [DATA_W-1:0]     mem_data,
    output logic [DATA_W/8-1:0]   mem_be,
    output logic                  full,
    output logic                  empty
);
    localparam int unsigned BE_W  = DATA_W / CWB_BYTE_W;
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    typedef struct packed {
        logic [DEPTH-1:0]             vld;
        logic [PTR_W-1:0]             head;
        logic [PTR_W-1:0]             tail;
        logic [DEPTH-1:0][ADDR_W-1:0] addr;
        logic [DEPTH-1:0][DATA_W-1:0] data;
        logic [DEPTH-1:0][BE_W-1:0]   be;
    } state_t;

    state_t s_d, s_q;

    logic [DEPTH-1:0] wr_match, rd_match, rd_sel, head_oh, merge_vec;
    logic             merge_any, wr_fire, mem_fire;
    logic [PTR_W-1:0] merge_idx;
    logic [DATA_W-1:0] fwd_data;
    logic [BE_W-1:0]   fwd_be;

    function automatic logic [PTR_W-1:0] ring_next(input logic [PTR_W-1:0] p);
        return (int'(p) == DEPTH - 1) ? '0 : p + 1'b1;
    endfunction

    cwb_match #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) wr_cmp_i (
        .slot_vld(s_q.vld), .slot_addr(s_q.addr), .key(wr_addr), .hit(wr_match)
    );

    cwb_match #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) rd_cmp_i (
        .slot_vld(s_q.vld), .slot_addr(s_q.addr), .key(rd_addr), .hit(rd_match)
    );

    assign rd_sel = rd_match & {DEPTH{rd_req}};

    cwb_fwd #(.DEPTH(DEPTH), .DATA_W(DATA_W), .PTR_W(PTR_W)) fwd_i (
        .sel(rd_sel), .oldest(s_q.head), .slot_data(s_q.data), .slot_be(s_q.be),
        .out_data(fwd_data), .out_be(fwd_be)
    );

    assign head_oh   = DEPTH'(1) << s_q.head;
    assign merge_vec = wr_match & ~head_oh;
    assign merge_any = |merge_vec;

    always_comb begin
        merge_idx = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (merge_vec[i]) merge_idx = PTR_W'(i);
        end
    end

    assign full      = s_q.vld[s_q.tail];
    assign empty     = !s_q.vld[s_q.head];
    assign wr_ready  = merge_any || !full;
    assign mem_valid = !empty;
    assign mem_addr  = s_q.addr[s_q.head];
    assign mem_data  = s_q.data[s_q.head];
    assign mem_be    = s_q.be[s_q.head];
    assign rd_hit    = |rd_sel;
    assign rd_data   = fwd_data;
    assign rd_be     = fwd_be;

    assign wr_fire  = wr_valid && wr_ready;
    assign mem_fire = mem_valid && mem_ready;

    always_comb begin
        s_d = s_q;
        if (mem_fire) begin
            s_d.vld[s_q.head] = 1'b0;
            s_d.head          = ring_next(s_q.head);
        end
        if (wr_fire) begin
            if (merge_any) begin
                for (int b = 0; b < BE_W; b++) begin
                    if (wr_be[b]) s_d.data[merge_idx][b*8 +: 8] = wr_data[b*8 +: 8];
                end
                s_d.be[merge_idx] = s_q.be[merge_idx] | wr_be;
            end else begin
                s_d.vld[s_q.tail]  = 1'b1;
                s_d.addr[s_q.tail] = wr_addr;
                s_d.be[s_q.tail]   = wr_be;
                for (int b = 0; b < BE_W; b++) begin
                    s_d.data[s_q.tail][b*8 +: 8] = wr_be[b] ? wr_data[b*8 +: 8] : 8'h00;
                end
                s_d.tail = ring_next(s_q.tail);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/cwb_chk.sv
module cwb_chk #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned DEPTH  = 4
) (
    input logic                clk,
    input logic                rst_n,
    input logic                wr_ready,
    input logic                rd_req,
    input logic                rd_hit,
    input logic                mem_valid,
    input logic                mem_ready,
    input logic [ADDR_W-1:0]   mem_addr,
    input logic [DATA_W-1:0]   mem_data,
    input logic [DATA_W/8-1:0] mem_be,
    input logic                full,
    input logic                empty
);
    // R2
    drain_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr)
                                       && $stable(mem_data) && $stable(mem_be)));

    // R2
    valid_tracks_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid == !empty);

    // R3
    full_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !(mem_valid && mem_ready)) |=> full);

    // R6
    stall_only_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_ready |-> full);

    // R7
    no_req_no_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |-> !rd_hit);

    // R1
    full_empty_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(full && empty));
endmodule

bind cwb_top cwb_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)) chk_i (.*);

// File: tb/cwb_top_tb.sv
module cwb_top_tb_top;
    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic        wv;
        logic [31:0] wa;
        logic [31:0] wd;
        logic [3:0]  wbe;
        logic        mr;
        logic        rq;
        logic [31:0] ra;
        logic        e_wrdy;
        logic        e_full;
        logic        e_empty;
        logic        e_mv;
        logic [31:0] e_ma;
        logic [31:0] e_md;
        logic [3:0]  e_mbe;
        logic        e_hit;
        logic [31:0] e_rd;
        logic [3:0]  e_rbe;
    } vec_t;

    // Expected outputs are those seen before the clock edge that applies the row.
    localparam vec_t VEC [0:14] = '{
        // 0: first store into empty buffer (R9 full-enable)
        '{1'b1, 32'h100, 32'h11223344, 4'hF, 1'b0, 1'b0, 32'h0,
          1'b1, 1'b0, 1'b1, 1'b0, 32'h0, 32'h0, 4'h0, 1'b0, 32'h0, 4'h0},
        // 1: partial store 0x104 (R9 zero fill); lookup 0x100 hits (R7)
        '{1'b1, 32'h104, 32'hAABBCCDD, 4'h3, 1'b0, 1'b1, 32'h100,
          1'b1, 1'b0, 1'b0, 1'b1, 32'h100, 32'h11223344, 4'hF, 1'b1, 32'h11223344, 4'hF},
        // 2: store to 0x104 merges into non-oldest slot (R4); lookup sees pre-merge
        '{1'b1, 32'h104, 32'h55667788, 4'hC, 1'b0, 1'b1, 32'h104,
          1'b1, 1'b0, 1'b0, 1'b1, 32'h100, 32'h11223344, 4'hF, 1'b1, 32'h0000CCDD, 4'h3},
        // 3: merged result visible (R4, R8); oldest drains
        '{1'b0, 32'h0, 32'h0, 4'h0, 1'b1, 1'b1, 32'h104,
          1'b1, 1'b0, 1'b0, 1'b1, 32'h100, 32'h11223344, 4'hF, 1'b1, 32'h5566CCDD, 4'hF},
        // 4: store to oldest slot's address takes a new slot (R5)
        '{1'b1, 32'h104, 32'h99000000, 4'h8, 1'b0, 1'b1, 32'h104,
          1'b1, 1'b0, 1'b0, 1'b1, 32'h104, 32'h5566CCDD, 4'hF, 1'b1, 32'h5566CCDD, 4'hF},
        // 5: two matching slots, newest byte wins (R8)
        '{1'b1, 32'h200, 32'h01020304, 4'hF, 1'b0, 1'b1, 32'h104,
          1'b1, 1'b0, 1'b0, 1'b1, 32'h104, 32'h5566CCDD, 4'hF, 1'b1, 32'h9966CCDD, 4'hF},
        // 6: fourth slot; lookup miss lets the read bypass (R7)
        '{1'b1, 32'h300, 32'hDEADBEEF, 4'hF, 1'b0, 1'b1, 32'h108,
          1'b1, 1'b0, 1'b0, 1'b1, 32'h104, 32'h5566CCDD, 4'hF, 1'b0, 32'h0, 4'h0},
        // 7: full, new address stalls (R6)
        '{1'b1, 32'h400, 32'h0A0B0C0D, 4'hF, 1'b0, 1'b1, 32'h300,
          1'b0, 1'b1, 1'b0, 1'b1, 32'h104, 32'h5566CCDD, 4'hF, 1'b1, 32'hDEADBEEF, 4'hF},
        // 8: full, but merge target exists so store accepted (R6, R4)
        '{1'b1, 32'h200, 32'hFFFFFFFF, 4'h1, 1'b0, 1'b1, 32'h200,
          1'b1, 1'b1, 1'b0, 1'b1, 32'h104, 32'h5566CCDD, 4'hF, 1'b1, 32'h01020304, 4'hF},
        // 9: merged bytes visible; drain starts (R8, R2)
        '{1'b0, 32'h0, 32'h0, 4'h0, 1'b1, 1'b1, 32'h200,
          1'b0, 1'b1, 1'b0, 1'b1, 32'h104, 32'h5566CCDD, 4'hF, 1'b1, 32'h010203FF, 4'hF},
        // 10: slot freed so the stalled store now enters (R3, R6)
        '{1'b1, 32'h400, 32'h0A0B0C0D, 4'hF, 1'b1, 1'b0, 32'h0,
          1'b1, 1'b0, 1'b0, 1'b1, 32'h104, 32'h99000000, 4'h8, 1'b0, 32'h0, 4'h0},
        // 11..13: drain in arrival order (R2)
        '{1'b0, 32'h0, 32'h0, 4'h0, 1'b1, 1'b0, 32'h0,
          1'b1, 1'b0, 1'b0, 1'b1, 32'h200, 32'h010203FF, 4'hF, 1'b0, 32'h0, 4'h0},
        '{1'b0, 32'h0, 32'h0, 4'h0, 1'b1, 1'b0, 32'h0,
          1'b1, 1'b0, 1'b0, 1'b1, 32'h300, 32'hDEADBEEF, 4'hF, 1'b0, 32'h0, 4'h0},
        '{1'b0, 32'h0, 32'h0, 4'h0, 1'b1, 1'b0, 32'h0,
          1'b1, 1'b0, 1'b0, 1'b1, 32'h400, 32'h0A0B0C0D, 4'hF, 1'b0, 32'h0, 4'h0},
        // 14: empty again, old address no longer hits (R7)
        '{1'b0, 32'h0, 32'h0, 4'h0, 1'b0, 1'b1, 32'h400,
          1'b1, 1'b0, 1'b1, 1'b0, 32'h0, 32'h0, 4'h0, 1'b0, 32'h0, 4'h0}
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_valid, wr_ready, rd_req, rd_hit, mem_valid, mem_ready, full, empty;
    logic [31:0] wr_addr, wr_data, rd_addr, rd_data, mem_addr, mem_data;
    logic [3:0]  wr_be, rd_be, mem_be;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cwb_top dut_i (
        .clk(clk), .rst_n(rst_n),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
        .wr_data(wr_data), .wr_be(wr_be),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_hit(rd_hit),
        .rd_data(rd_data), .rd_be(rd_be),
        .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr),
        .mem_data(mem_data), .mem_be(mem_be),
        .full(full), .empty(empty)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic drive(input logic wv, input logic [31:0] wa, input logic [31:0] wd,
                         input logic [3:0] wbe, input logic mr,
                         input logic rq, input logic [31:0] ra);
        @(negedge clk);
        wr_valid = wv; wr_addr = wa; wr_data = wd; wr_be = wbe;
        mem_ready = mr; rd_req = rq; rd_addr = ra;
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        wr_valid = 1'b0; wr_addr = '0; wr_data = '0; wr_be = '0;
        mem_ready = 1'b0; rd_req = 1'b0; rd_addr = '0;
        @(negedge clk);
        @(negedge clk);
        #1;
        chk("R1", "empty", 32'(empty), 32'd1);
        chk("R1", "full", 32'(full), 32'd0);
        chk("R1", "mem_valid", 32'(mem_valid), 32'd0);
        chk("R1", "wr_ready", 32'(wr_ready), 32'd1);
        rst_n = 1'b1;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        do_reset();

        for (int i = 0; i < 15; i++) begin
            vec_t v;
            v = VEC[i];
            drive(v.wv, v.wa, v.wd, v.wbe, v.mr, v.rq, v.ra);
            chk("R6", $sformatf("v%0d wr_ready", i), 32'(wr_ready), 32'(v.e_wrdy));
            chk("R6", $sformatf("v%0d full", i), 32'(full), 32'(v.e_full));
            chk("R2", $sformatf("v%0d empty", i), 32'(empty), 32'(v.e_empty));
            chk("R2", $sformatf("v%0d mem_valid", i), 32'(mem_valid), 32'(v.e_mv));
            if (v.e_mv) begin
                chk("R2", $sformatf("v%0d mem_addr", i), mem_addr, v.e_ma);
                chk("R9", $sformatf("v%0d mem_data", i), mem_data, v.e_md);
                chk("R4", $sformatf("v%0d mem_be", i), 32'(mem_be), 32'(v.e_mbe));
            end
            chk("R7", $sformatf("v%0d rd_hit", i), 32'(rd_hit), 32'(v.e_hit));
            if (v.e_hit) begin
                chk("R8", $sformatf("v%0d rd_data", i), rd_data, v.e_rd);
                chk("R8", $sformatf("v%0d rd_be", i), 32'(rd_be), 32'(v.e_rbe));
            end
        end

        // R3: slot held while memory stalls, no release without handshake
        drive(1'b1, 32'h600, 32'h12345678, 4'hF, 1'b0, 1'b0, 32'h0);
        for (int c = 0; c < 3; c++) begin
            drive(1'b0, 32'h0, 32'h0, 4'h0, 1'b0, 1'b0, 32'h0);
            chk("R3", "stalled mem_valid", 32'(mem_valid), 32'd1);
            chk("R3", "stalled mem_addr", mem_addr, 32'h600);
        end

        // R1: reset with a pending slot drops it
        do_reset();

        // R10: top address bit must take part in compares
        drive(1'b1, 32'h00000500, 32'hA0A0A0A0, 4'hF, 1'b0, 1'b0, 32'h0);
        drive(1'b1, 32'h00000504, 32'hB0B0B0B0, 4'hF, 1'b0, 1'b0, 32'h0);
        drive(1'b1, 32'h80000504, 32'hC0C0C0C0, 4'hF, 1'b0, 1'b1, 32'h80000504);
        chk("R10", "lookup high-bit alias", 32'(rd_hit), 32'd0);
        drive(1'b0, 32'h0, 32'h0, 4'h0, 1'b1, 1'b1, 32'h00000504);
        chk("R10", "lookup exact", rd_data, 32'hB0B0B0B0);
        chk("R10", "drain 1st", mem_addr, 32'h00000500);
        drive(1'b0, 32'h0, 32'h0, 4'h0, 1'b1, 1'b0, 32'h0);
        chk("R10", "drain 2nd", mem_addr, 32'h00000504);
        chk("R10", "drain 2nd data", mem_data, 32'hB0B0B0B0);
        drive(1'b0, 32'h0, 32'h0, 4'h0, 1'b1, 1'b0, 32'h0);
        chk("R10", "drain 3rd (no merge)", mem_addr, 32'h80000504);
        chk("R10", "drain 3rd data", mem_data, 32'hC0C0C0C0);
        drive(1'b0, 32'h0, 32'h0, 4'h0, 1'b0, 1'b0, 32'h0);
        chk("R2", "empty after drain", 32'(empty), 32'd1);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule